// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Edge Interrupts

This block is the register and pin logic of a small general-purpose I/O port. A serial-bus slave in front of it turns host transactions into single-cycle register writes and reads; the port holds the per-pin configuration, drives the pad output, output-enable and pull-up controls, and builds the read-only pin-state and interrupt-flag views. A separate deglitch block supplies a filtered copy of the pad inputs, and each pin selects the filtered or the raw view for its edge detection.

Each input pin can raise an interrupt. When neither edge-enable bit is set, any change of the pin counts. That flag clears when the host reads the pin-state register, or when the pin goes back to the value it had at that last read. When an edge-enable bit is set, only the chosen edges count, and only a pin-state read clears the flag. The OR of all flags drives an active-low, open-drain interrupt line, given here as a pull-low enable.

Pad inputs are taken to be synchronous to `clk`. The asynchronous reset input passes through a two-stage release synchronizer.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the registers read as follows: direction 0xFF (all inputs), output value 0xFF, float 0x00, invert 0x00, interrupt enable 0x00, rise select 0x00, fall select 0x00, filter select 0xFF, and flags 0x00. No pad is driven.
- R2: The register offsets are: 0 pin state (read-only), 1 interrupt flags (read-only), 2 direction, 3 output value, 4 float, 5 invert, 6 pull-up, 7 interrupt enable, 8 rise select, 9 fall select, 10 filter select. A write with `bus_wr` high takes effect at the next clock edge. A read with `bus_rd` high places the data on `bus_rdata` after that edge, and `bus_rdata` holds it until the next read. Other offsets read 0x00. Writes to offsets 0 and 1 change nothing.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. `pad_oe` is set for output pins whose float bit is 0. `pad_out` always equals the output-value register.
- R4: `pad_pu` is set for pins that are inputs and have the pull-up bit set.
- R5: A pin-state read returns, for an input pin, the raw pad value XOR the invert bit. For an output pin it returns the output-value bit, whatever the float bit is.
- R6: A filter-select bit of 1 makes the pin's edge detection use `pad_filt`. A bit of 0 makes it use `pad_in`.
- R7: With rise and fall select both 0, an enabled input pin flags on any change of its sensed value. The flag clears on a pin-state read, or when the sensed value equals the value captured at the last pin-state read.
- R8: With rise select only, rising edges flag. With fall select only, falling edges flag. With both, either edge flags. In these modes only a pin-state read clears the flag, and an edge in the same cycle as that read leaves the flag set.
- R9: A pin that is an output, or whose interrupt-enable bit is 0, never has a flag set.
- R10: `irq_pull_low` is 1 exactly when at least one flag is set.
- R11: The pull-up register resets to all zeros when `PULL_RST_ONES` is 0 and to all ones when it is 1.
- R12: Taking `rst_n` low at any time returns every register and output to its R1 state at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Registered read data |
| pad_in | input | NPIN | Raw pad input levels |
| pad_filt | input | NPIN | Deglitched pad input levels |
| pad_out | output | NPIN | Pad output levels |
| pad_oe | output | NPIN | Pad output enables |
| pad_pu | output | NPIN | Pad pull-up enables |
| irq_pull_low | output | 1 | Pull the open-drain interrupt line low |

## Verification
The hardest cases to reach from the ports are those where a flag's fate depends on the value captured at the last pin-state read. One is the return-to-snapshot clear in the any-change mode. The other is an edge that lands in the same clock as a clearing read in an explicit edge mode. The stimulus first takes a snapshot with a pin-state read. It then moves single pads at the falling clock edge, so each change meets a known rising edge. In the same-cycle case it raises the read strobe on the same falling edge as the pad change. A behavioural reference model follows every clock and is compared with all outputs, so each ordering is also checked in the cycles after it.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATE = 4'd0,
    REG_ISTAT = 4'd1,
    REG_DIR   = 4'd2,
    REG_OUT   = 4'd3,
    REG_FLOAT = 4'd4,
    REG_INV   = 4'd5,
    REG_PULL  = 4'd6,
    REG_IEN   = 4'd7,
    REG_RISE  = 4'd8,
    REG_FALL  = 4'd9,
    REG_FILT  = 4'd10
  } reg_addr_e;

  // writable registers sit at consecutive offsets starting at REG_DIR
  localparam int FIRST_CFG = 2;
  localparam int NCFG      = 9;

  // {fall_sel, rise_sel}
  typedef enum logic [1:0] {
    EDGE_ANY_RET = 2'b00,
    EDGE_RISE    = 2'b01,
    EDGE_FALL    = 2'b10,
    EDGE_BOTH    = 2'b11
  } edge_mode_e;

  // reset level of every bit of writable register number idx
  function automatic logic cfg_reset_bit(input int idx, input bit pull_ones);
    case (idx + FIRST_CFG)
      int'(REG_DIR), int'(REG_OUT), int'(REG_FILT): cfg_reset_bit = 1'b1;
      int'(REG_PULL):                               cfg_reset_bit = pull_ones;
      default:                                      cfg_reset_bit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_edge_pkg::*;
#(
  parameter int NPIN          = 8,
  parameter bit PULL_RST_ONES = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [NPIN-1:0]              wr_data,
  output logic [NCFG-1:0][NPIN-1:0]    cfg_q
);

  for (genvar g = 0; g < NCFG; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(FIRST_CFG + g);
    localparam logic              RST_BIT = cfg_reset_bit(g, PULL_RST_ONES);

    logic [NPIN-1:0] val_q;
    logic [NPIN-1:0] val_d;
    logic            val_en;

    always_comb begin
      val_en = wr_en && (wr_addr == MY_ADDR);
      val_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= {NPIN{RST_BIT}};
      else if (val_en) val_q <= val_d;
    end

    assign cfg_q[g] = val_q;
  end

endmodule

// File: rtl/gpio_irq_lane.sv
module gpio_irq_lane
  import gpio_edge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sense_i,
  input  logic       active_i,
  input  edge_mode_e mode_i,
  input  logic       rd_state_i,
  output logic       flag_o
);
  logic prev_q, prev_d;
  logic snap_q, snap_d;
  logic flag_q, flag_d;
  logic rise, fall, trig;

  always_comb begin
    rise   = sense_i & ~prev_q;
    fall   = ~sense_i & prev_q;
    prev_d = sense_i;
    snap_d = rd_state_i ? sense_i : snap_q;
    trig   = 1'b0;
    flag_d = 1'b0;
    case (mode_i)
      EDGE_RISE: trig = rise;
      EDGE_FALL: trig = fall;
      EDGE_BOTH: trig = rise | fall;
      default:   trig = 1'b0;
    endcase
    if (!active_i) begin
      flag_d = 1'b0;
    end else if (mode_i == EDGE_ANY_RET) begin
      // a read takes a fresh snapshot equal to the present value, so nothing is left pending
      if (rd_state_i) flag_d = 1'b0;
      else            flag_d = (flag_q | rise | fall) & (sense_i ^ snap_q);
    end else begin
      flag_d = trig | (flag_q & ~rd_state_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      snap_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      snap_q <= snap_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int NPIN          = 8,
  parameter bit PULL_RST_ONES = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [3:0]      bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] pad_filt,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_pu,
  output logic            irq_pull_low
);

  localparam int IDX_DIR   = int'(REG_DIR)   - FIRST_CFG;
  localparam int IDX_OUT   = int'(REG_OUT)   - FIRST_CFG;
  localparam int IDX_FLOAT = int'(REG_FLOAT) - FIRST_CFG;
  localparam int IDX_INV   = int'(REG_INV)   - FIRST_CFG;
  localparam int IDX_PULL  = int'(REG_PULL)  - FIRST_CFG;
  localparam int IDX_IEN   = int'(REG_IEN)   - FIRST_CFG;
  localparam int IDX_RISE  = int'(REG_RISE)  - FIRST_CFG;
  localparam int IDX_FALL  = int'(REG_FALL)  - FIRST_CFG;
  localparam int IDX_FILT  = int'(REG_FILT)  - FIRST_CFG;

  logic                      rst_n_s;
  logic [NCFG-1:0][NPIN-1:0] cfg_q;
  logic [NPIN-1:0] cfg_dir, cfg_out, cfg_float, cfg_inv, cfg_pull;
  logic [NPIN-1:0] cfg_ien, cfg_rise, cfg_fall, cfg_filt;
  logic [NPIN-1:0] sense, active, istat, state_val;
  logic            rd_state;
  logic [NPIN-1:0] rdata_q, rdata_d;

  gpio_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  gpio_cfg_regs #(
    .NPIN          (NPIN),
    .PULL_RST_ONES (PULL_RST_ONES)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (bus_wr),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .cfg_q   (cfg_q)
  );

  always_comb begin
    cfg_dir   = cfg_q[IDX_DIR];
    cfg_out   = cfg_q[IDX_OUT];
    cfg_float = cfg_q[IDX_FLOAT];
    cfg_inv   = cfg_q[IDX_INV];
    cfg_pull  = cfg_q[IDX_PULL];
    cfg_ien   = cfg_q[IDX_IEN];
    cfg_rise  = cfg_q[IDX_RISE];
    cfg_fall  = cfg_q[IDX_FALL];
    cfg_filt  = cfg_q[IDX_FILT];
  end

  always_comb begin
    sense     = (cfg_filt & pad_filt) | (~cfg_filt & pad_in);
    active    = cfg_dir & cfg_ien;
    rd_state  = bus_rd && (bus_addr == REG_STATE);
    state_val = (cfg_dir & (pad_in ^ cfg_inv)) | (~cfg_dir & cfg_out);
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_lane
    gpio_irq_lane u_lane (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .sense_i    (sense[p]),
      .active_i   (active[p]),
      .mode_i     (edge_mode_e'({cfg_fall[p], cfg_rise[p]})),
      .rd_state_i (rd_state),
      .flag_o     (istat[p])
    );
  end

  always_comb begin
    case (bus_addr)
      REG_STATE: rdata_d = state_val;
      REG_ISTAT: rdata_d = istat;
      REG_DIR:   rdata_d = cfg_dir;
      REG_OUT:   rdata_d = cfg_out;
      REG_FLOAT: rdata_d = cfg_float;
      REG_INV:   rdata_d = cfg_inv;
      REG_PULL:  rdata_d = cfg_pull;
      REG_IEN:   rdata_d = cfg_ien;
      REG_RISE:  rdata_d = cfg_rise;
      REG_FALL:  rdata_d = cfg_fall;
      REG_FILT:  rdata_d = cfg_filt;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata    = rdata_q;
  assign pad_out      = cfg_out;
  assign pad_oe       = ~cfg_dir & ~cfg_float;
  assign pad_pu       = cfg_dir & cfg_pull;
  assign irq_pull_low = |istat;

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_edge_pkg::*;
#(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [3:0]      bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_pu,
  input logic            irq_pull_low,
  input logic [NPIN-1:0] istat,
  input logic [NPIN-1:0] dir,
  input logic [NPIN-1:0] ien
);

  // R4
  oe_pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);

  // R9
  out_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (istat & ~(dir & ien)) == '0);

  // R3
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_OUT) |=> pad_out == $past(bus_wdata));

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull_low) |-> |(istat & ien));

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NPIN(NPIN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe),
  .pad_pu       (pad_pu),
  .irq_pull_low (irq_pull_low),
  .istat        (istat),
  .dir          (cfg_dir),
  .ien          (cfg_ien)
);

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, pad_in = '0, pad_filt = '0;
  logic [N-1:0] bus_rdata, pad_out, pad_oe, pad_pu, pad_pu2;
  logic [N-1:0] rdata2, out2, oe2;
  logic irq_pull_low, irq2;

  int tests = 0, fails = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_port #(.NPIN(N), .PULL_RST_ONES(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_filt(pad_filt),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .irq_pull_low(irq_pull_low));

  gpio_edge_port #(.NPIN(N), .PULL_RST_ONES(1'b1)) u_dut_pu (
    .clk(clk), .rst_n(rst_n), .bus_wr(1'b0), .bus_rd(1'b0), .bus_addr(4'd0),
    .bus_wdata('0), .bus_rdata(rdata2), .pad_in('0), .pad_filt('0),
    .pad_out(out2), .pad_oe(oe2), .pad_pu(pad_pu2), .irq_pull_low(irq2));

  // reference model state
  bit [N-1:0] m_dir, m_out, m_flt, m_inv, m_pu, m_ien, m_rise, m_fall, m_filt;
  bit [N-1:0] m_prev, m_snap, m_stat, m_rdata;

  function automatic bit [N-1:0] model_read(input int a);
    bit [N-1:0] v = '0;
    case (a)
      0: for (int i = 0; i < N; i++) v[i] = m_dir[i] ? (pad_in[i] ^ m_inv[i]) : m_out[i];
      1: v = m_stat;   2: v = m_dir;  3: v = m_out;  4: v = m_flt;
      5: v = m_inv;    6: v = m_pu;   7: v = m_ien;  8: v = m_rise;
      9: v = m_fall;  10: v = m_filt;
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '1; m_out = '1; m_flt = '0; m_inv = '0; m_pu = '0;
      m_ien = '0; m_rise = '0; m_fall = '0; m_filt = '1;
      m_prev = '0; m_snap = '0; m_stat = '0; m_rdata = '0;
    end else begin
      bit [N-1:0] ns, nsnap, sel;
      bit rdst;
      rdst = bus_rd && bus_addr == 4'd0;
      for (int i = 0; i < N; i++) begin
        bit chg, trig;
        sel[i] = m_filt[i] ? pad_filt[i] : pad_in[i];
        chg = sel[i] != m_prev[i];
        if (!(m_dir[i] && m_ien[i])) ns[i] = 1'b0;
        else if (!m_rise[i] && !m_fall[i])
          ns[i] = !rdst && (m_stat[i] || chg) && (sel[i] != m_snap[i]);
        else begin
          trig = (m_rise[i] && sel[i] && !m_prev[i]) || (m_fall[i] && !sel[i] && m_prev[i]);
          ns[i] = trig || (m_stat[i] && !rdst);
        end
        nsnap[i] = rdst ? sel[i] : m_snap[i];
      end
      if (bus_rd) m_rdata = model_read(int'(bus_addr));
      m_stat = ns; m_snap = nsnap; m_prev = sel;
      if (bus_wr)
        case (int'(bus_addr))
          2: m_dir = bus_wdata;  3: m_out = bus_wdata;  4: m_flt = bus_wdata;
          5: m_inv = bus_wdata;  6: m_pu = bus_wdata;   7: m_ien = bus_wdata;
          8: m_rise = bus_wdata; 9: m_fall = bus_wdata; 10: m_filt = bus_wdata;
          default: ;
        endcase
    end
  end

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      check("R2 rdata", bus_rdata, m_rdata);
      check("R3 pad_out", pad_out, m_out);
      check("R3 pad_oe", pad_oe, ~m_dir & ~m_flt);
      check("R4 pad_pu", pad_pu, m_dir & m_pu);
      check("R10 irq", {7'd0, irq_pull_low}, {7'd0, |m_stat});
    end
  end

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [N-1:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 4'(a);
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pin(input int idx, input logic v);
    @(negedge clk); pad_in[idx] = v;
    @(negedge clk);
  endtask

  task automatic irq_is(input string tag, input logic e);
    check(tag, {7'd0, irq_pull_low}, {7'd0, e});
  endtask

  logic [N-1:0] d;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    // R1 reset values, read through the bus
    rd(0, d);  check("R1 state", d, 8'h00);
    rd(1, d);  check("R1 flags", d, 8'h00);
    rd(2, d);  check("R1 dir", d, 8'hFF);
    rd(3, d);  check("R1 out", d, 8'hFF);
    rd(4, d);  check("R1 float", d, 8'h00);
    rd(5, d);  check("R1 inv", d, 8'h00);
    rd(6, d);  check("R11 pull zero", d, 8'h00);
    rd(7, d);  check("R1 ien", d, 8'h00);
    rd(8, d);  check("R1 rise", d, 8'h00);
    rd(9, d);  check("R1 fall", d, 8'h00);
    rd(10, d); check("R1 filt", d, 8'hFF);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R11 pull ones variant", pad_pu2, 8'hFF);

    // R3 direction, output value, float
    wr(2, 8'h0F); wr(3, 8'hA5); wr(4, 8'h30);
    check("R3 oe", pad_oe, 8'hC0);
    check("R3 out", pad_out, 8'hA5);

    // R5 state view with inversion
    @(negedge clk); pad_in = 8'h3C;
    wr(5, 8'h05);
    rd(0, d); check("R5 state", d, 8'hA9);

    // R4 pull-up on inputs only
    wr(6, 8'hFF);
    check("R4 pu", pad_pu, 8'h0F);

    // R2 unknown offset and read-only writes
    rd(15, d); check("R2 unmapped", d, 8'h00);
    wr(0, 8'h55); wr(1, 8'hFF);
    rd(0, d); check("R2 ro state", d, 8'hA9);
    rd(1, d); check("R2 ro flags", d, 8'h00);

    // interrupt setup: all inputs, raw view, any-change mode
    @(negedge clk); pad_in = 8'h00;
    wr(5, 8'h00); wr(4, 8'h00); wr(2, 8'hFF); wr(10, 8'h00); wr(7, 8'hFF);
    rd(0, d);
    irq_is("R7 idle", 1'b0);

    // R7 return-to-snapshot clear
    pin(0, 1'b1); irq_is("R7 set", 1'b1);
    rd(1, d); check("R7 flags", d, 8'h01);
    pin(0, 1'b0); irq_is("R7 return clears", 1'b0);

    // R7 read clear, then change away from snapshot
    pin(1, 1'b1); irq_is("R7 set b1", 1'b1);
    rd(0, d); check("R7 read data", d, 8'h02);
    irq_is("R7 read clears", 1'b0);
    pin(1, 1'b0); irq_is("R7 away from snap", 1'b1);
    rd(0, d); irq_is("R7 read clears 2", 1'b0);

    // R8 rising only on pin 2
    wr(8, 8'h04);
    pin(2, 1'b1); irq_is("R8 rise set", 1'b1);
    pin(2, 1'b0); irq_is("R8 no return clear", 1'b1);
    rd(0, d); irq_is("R8 read clear", 1'b0);

    // R8 falling only on pin 3
    wr(9, 8'h08);
    pin(3, 1'b1); irq_is("R8 rise ignored", 1'b0);
    pin(3, 1'b0); irq_is("R8 fall set", 1'b1);
    rd(0, d); irq_is("R8 read clear f", 1'b0);

    // R8 both edges on pin 4
    wr(8, 8'h14); wr(9, 8'h18);
    pin(4, 1'b1); irq_is("R8 both rise", 1'b1);
    rd(0, d); irq_is("R8 both clr", 1'b0);
    pin(4, 1'b0); irq_is("R8 both fall", 1'b1);
    rd(0, d);

    // R8 edge in the same cycle as the clearing read
    @(negedge clk); pad_in[2] = 1'b1; bus_rd = 1'b1; bus_addr = 4'd0;
    @(negedge clk); bus_rd = 1'b0;
    check("R8 same-cycle data", bus_rdata, 8'h04);
    irq_is("R8 same-cycle kept", 1'b1);
    rd(0, d); irq_is("R8 later clear", 1'b0);
    pin(2, 1'b0);

    // R9 output pin and disabled pin
    wr(2, 8'hDF);
    pin(5, 1'b1); irq_is("R9 output pin", 1'b0);
    pin(5, 1'b0);
    wr(2, 8'hFF); wr(7, 8'hBF);
    pin(6, 1'b1); irq_is("R9 disabled pin", 1'b0);
    pin(6, 1'b0);
    wr(7, 8'hFF); rd(0, d);

    // R6 filter selection on pin 7
    wr(10, 8'h80); rd(0, d);
    pin(7, 1'b1); irq_is("R6 raw ignored", 1'b0);
    @(negedge clk); pad_filt[7] = 1'b1; @(negedge clk);
    irq_is("R6 filtered edge", 1'b1);
    rd(0, d); irq_is("R6 clr", 1'b0);
    wr(10, 8'h00);
    pin(7, 1'b0); irq_is("R6 raw after deselect", 1'b1);

    // R12 asynchronous reset in mid-run
    @(negedge clk); cmp_en = 1'b0; pad_in = '0; pad_filt = '0;
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    check("R12 irq", {7'd0, irq_pull_low}, 8'h00);
    check("R12 oe", pad_oe, 8'h00);
    check("R12 out", pad_out, 8'hFF);
    check("R12 rdata", bus_rdata, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    rd(2, d);  check("R12 dir", d, 8'hFF);
    rd(7, d);  check("R12 ien", d, 8'h00);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule